// File: doc/BRIEF.md
# Codec Serial Control Word Sequencer

This block sits on the host side of a 16-bit serial link to a 14-bit audio codec and decides which word the serial transmitter sends next. After reset it holds the codec's reset line low for a programmable number of cycles. It then plays out a fixed setup program. The program has three pairs of words, each a secondary-request word followed by the register value that the request covers. The first register value sets the filter and clock dividers, the second sets the conversion dividers, and the third is the control register.

Once setup is finished, the block turns each offered 14-bit sample into a primary word with tag 00 in the two low bits. An input-switch request sends the current sample with tag 11 instead. The next word after it is a fixed control value that selects either the main input or the auxiliary input. After that word the link is back in primary mode.

Words leave the block over a valid/ready handshake and are never dropped or reordered. Words received from the codec are sign-extended from their upper 14 bits to a 32-bit sample.

Top module: `codec_word_sequencer`

## Requirements
- R1: After reset is released, `codecRstN` stays low for RST_CYC rising edges and rises on edge RST_CYC. `txValid` is low for that whole time.
- R2: The setup program is, in order: 0x0003, the filter word, 0x0003, the conversion word, 0x0003, the control word.
- R3: Setup words carry their payload in bits 15..2. The low two bits are forced to 00 for the filter word, 10 for the conversion word and 11 for the control word.
- R4: `cfgDone` rises in the cycle after the sixth setup word is accepted. Until then `smpReady` and `swReady` stay low.
- R5: While `txValid` is high and `txReady` is low, `txValid` and `txWord` hold their values.
- R6: A sample accepted with `smpValid && smpReady` appears on the next edge as `txWord = {smpIn, 2'b00}` with `txValid` high.
- R7: An accepted switch request sends `{smpIn, 2'b11}`, then 0x0063 when `swAux` was 0 or 0x0073 when it was 1. The word after that is again a primary word with tag 00.
- R8: When both `swValid` and `smpValid` are high, the switch request wins: `smpReady` is low and `swReady` is high.
- R9: On the edge after `rxValid`, `rxSample` equals bits 15..2 of `rxWord` sign-extended to 32 bits, and `rxSmpValid` pulses high for one cycle.
- R10: While reset is asserted, `txValid`, `cfgDone`, `rxSmpValid` and `codecRstN` are all low.
- R11: In run mode, a new word is taken only while no word is pending. A primary word is dropped from `txValid` on the edge that accepts it and is not sent twice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgA | input | 14 | Payload of the filter/clock setup word |
| cfgB | input | 14 | Payload of the conversion setup word |
| cfgCtl | input | 14 | Payload of the control setup word |
| smpValid | input | 1 | Sample offered |
| smpReady | output | 1 | Sample taken this cycle if offered |
| smpIn | input | 14 | Outgoing sample, also used for the tagged switch word |
| swValid | input | 1 | Input-switch request |
| swReady | output | 1 | Switch request taken this cycle if offered |
| swAux | input | 1 | 1 selects the auxiliary input, 0 selects the main input |
| txValid | output | 1 | Word pending for the transmitter |
| txReady | input | 1 | Transmitter takes the word |
| txWord | output | 16 | Word to transmit |
| rxValid | input | 1 | Received word present |
| rxWord | input | 16 | Received codec word |
| rxSmpValid | output | 1 | Sign-extended sample valid |
| rxSample | output | 32 | Sign-extended received sample |
| codecRstN | output | 1 | Active-low codec reset |
| cfgDone | output | 1 | Setup program finished |

## Verification
A word that is handed in, whether a setup step, a sample or a switch, appears on `txWord` one edge later. A received word shows up on `rxSample` one edge after `rxValid`. `cfgDone` follows the sixth accept by one edge, and `codecRstN` rises on edge RST_CYC after reset is released.

The bench changes inputs only after a clock edge and reads outputs on the following falling edge. Each check is therefore made one half cycle after the edge on which its result is due. Stall cycles on `txReady` are read one by one to confirm that the pending word holds.

// File: rtl/codec_seq_pkg.sv
`timescale 1ns/1ps
package codec_seq_pkg;
  localparam int WORD_W  = 16;
  localparam int TAG_W   = 2;
  localparam int SMP_W   = WORD_W - TAG_W;
  localparam int CFG_LEN = 6;
  localparam int IDX_W   = $clog2(CFG_LEN);

  localparam logic [TAG_W-1:0] TAG_PRI = 2'b00;
  localparam logic [TAG_W-1:0] TAG_REQ = 2'b11;
  localparam logic [TAG_W-1:0] TAG_FLT = 2'b00;
  localparam logic [TAG_W-1:0] TAG_CNV = 2'b10;
  localparam logic [TAG_W-1:0] TAG_CTL = 2'b11;

  localparam logic [WORD_W-1:0] CTL_IN_MAIN = 16'h0063;
  localparam logic [WORD_W-1:0] CTL_IN_AUX  = 16'h0073;

  typedef enum logic [1:0] {
    SEL_CFG,
    SEL_SMP,
    SEL_SWTAG,
    SEL_SWCTL
  } wordSel_e;

  typedef struct packed {
    logic             load;
    wordSel_e         sel;
    logic             clr;
    logic [IDX_W-1:0] cfgIdx;
  } seqStrobe_t;
endpackage

// File: rtl/codec_seq_ctrl.sv
`timescale 1ns/1ps
module codec_seq_ctrl
  import codec_seq_pkg::*;
#(
  parameter int RST_CYC = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       txValid,
  input  logic       txReady,
  input  logic       smpValid,
  input  logic       swValid,
  output logic       smpReady,
  output logic       swReady,
  output logic       codecRstN,
  output logic       cfgDone,
  output seqStrobe_t strb
);
  localparam int CNT_W = $clog2(RST_CYC + 1);

  typedef enum logic [2:0] {ST_HOLD, ST_CFG, ST_RUN, ST_SWTAG, ST_SWCTL} seqState_e;

  seqState_e        state, stateNxt;
  logic [CNT_W-1:0] holdCnt;
  logic [IDX_W-1:0] idx, idxNxt;
  logic             accept, lastCfg, holdEnd;

  assign accept  = txValid && txReady;
  assign lastCfg = (idx == IDX_W'(CFG_LEN - 1));
  assign holdEnd = (holdCnt == CNT_W'(RST_CYC - 1));

  always_comb begin
    stateNxt    = state;
    idxNxt      = idx;
    strb        = '0;
    strb.cfgIdx = idx;
    case (state)
      ST_HOLD: if (holdEnd) begin
        stateNxt    = ST_CFG;
        strb.load   = 1'b1;
        strb.sel    = SEL_CFG;
        strb.cfgIdx = '0;
      end
      ST_CFG: if (accept) begin
        if (lastCfg) begin
          strb.clr = 1'b1;
          stateNxt = ST_RUN;
        end else begin
          idxNxt      = idx + 1'b1;
          strb.load   = 1'b1;
          strb.sel    = SEL_CFG;
          strb.cfgIdx = idx + 1'b1;
        end
      end
      ST_RUN: begin
        if (txValid) begin
          strb.clr = txReady;
        end else if (swValid) begin
          strb.load = 1'b1;
          strb.sel  = SEL_SWTAG;
          stateNxt  = ST_SWTAG;
        end else if (smpValid) begin
          strb.load = 1'b1;
          strb.sel  = SEL_SMP;
        end
      end
      ST_SWTAG: if (accept) begin
        strb.load = 1'b1;
        strb.sel  = SEL_SWCTL;
        stateNxt  = ST_SWCTL;
      end
      ST_SWCTL: if (accept) begin
        strb.clr = 1'b1;
        stateNxt = ST_RUN;
      end
      default: stateNxt = ST_HOLD;
    endcase
  end

  assign swReady  = (state == ST_RUN) && !txValid;
  assign smpReady = swReady && !swValid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_HOLD;
      holdCnt   <= '0;
      idx       <= '0;
      codecRstN <= 1'b0;
      cfgDone   <= 1'b0;
    end else begin
      state <= stateNxt;
      idx   <= idxNxt;
      if (state == ST_HOLD) begin
        holdCnt <= holdCnt + 1'b1;
        if (holdEnd) codecRstN <= 1'b1;
      end
      if (state == ST_CFG && accept && lastCfg) cfgDone <= 1'b1;
    end
  end
endmodule

// File: rtl/codec_seq_dp.sv
`timescale 1ns/1ps
module codec_seq_dp
  import codec_seq_pkg::*;
#(
  parameter int RX_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strb,
  input  logic [SMP_W-1:0]  cfgA,
  input  logic [SMP_W-1:0]  cfgB,
  input  logic [SMP_W-1:0]  cfgCtl,
  input  logic [SMP_W-1:0]  smpIn,
  input  logic              swAux,
  input  logic              rxValid,
  input  logic [WORD_W-1:0] rxWord,
  output logic              txValid,
  output logic [WORD_W-1:0] txWord,
  output logic              rxSmpValid,
  output logic [RX_W-1:0]   rxSample
);
  localparam int RX_PAD   = RX_W - WORD_W;
  localparam int RX_SHIFT = RX_W - SMP_W;
  localparam logic [WORD_W-1:0] REQ_WORD = {{SMP_W{1'b0}}, TAG_REQ};

  logic                   auxSel;
  logic [WORD_W-1:0]      nextWord;
  logic signed [RX_W-1:0] rxAligned;

  always_comb begin
    nextWord = REQ_WORD;
    case (strb.sel)
      SEL_CFG: begin
        case (strb.cfgIdx)
          IDX_W'(1): nextWord = {cfgA,   TAG_FLT};
          IDX_W'(3): nextWord = {cfgB,   TAG_CNV};
          IDX_W'(5): nextWord = {cfgCtl, TAG_CTL};
          default:   nextWord = REQ_WORD;
        endcase
      end
      SEL_SMP:   nextWord = {smpIn, TAG_PRI};
      SEL_SWTAG: nextWord = {smpIn, TAG_REQ};
      SEL_SWCTL: nextWord = auxSel ? CTL_IN_AUX : CTL_IN_MAIN;
      default:   nextWord = REQ_WORD;
    endcase
  end

  // Received word placed at the top of the wide register, then shifted down arithmetically
  assign rxAligned = {rxWord, {RX_PAD{1'b0}}};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txValid    <= 1'b0;
      txWord     <= '0;
      auxSel     <= 1'b0;
      rxSmpValid <= 1'b0;
      rxSample   <= '0;
    end else begin
      if (strb.load) begin
        txValid <= 1'b1;
        txWord  <= nextWord;
        if (strb.sel == SEL_SWTAG) auxSel <= swAux;
      end else if (strb.clr) begin
        txValid <= 1'b0;
      end
      rxSmpValid <= rxValid;
      if (rxValid) rxSample <= rxAligned >>> RX_SHIFT;
    end
  end
endmodule

// File: rtl/codec_word_sequencer.sv
`timescale 1ns/1ps
module codec_word_sequencer
  import codec_seq_pkg::*;
#(
  parameter int RST_CYC = 16,
  parameter int RX_W    = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [SMP_W-1:0]  cfgA,
  input  logic [SMP_W-1:0]  cfgB,
  input  logic [SMP_W-1:0]  cfgCtl,
  input  logic              smpValid,
  output logic              smpReady,
  input  logic [SMP_W-1:0]  smpIn,
  input  logic              swValid,
  output logic              swReady,
  input  logic              swAux,
  output logic              txValid,
  input  logic              txReady,
  output logic [WORD_W-1:0] txWord,
  input  logic              rxValid,
  input  logic [WORD_W-1:0] rxWord,
  output logic              rxSmpValid,
  output logic [RX_W-1:0]   rxSample,
  output logic              codecRstN,
  output logic              cfgDone
);
  seqStrobe_t strb;

  codec_seq_ctrl #(.RST_CYC(RST_CYC)) ctrl_i (
    .clk(clk), .rstN(rstN), .txValid(txValid), .txReady(txReady),
    .smpValid(smpValid), .swValid(swValid), .smpReady(smpReady),
    .swReady(swReady), .codecRstN(codecRstN), .cfgDone(cfgDone), .strb(strb)
  );

  codec_seq_dp #(.RX_W(RX_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .cfgA(cfgA), .cfgB(cfgB),
    .cfgCtl(cfgCtl), .smpIn(smpIn), .swAux(swAux), .rxValid(rxValid),
    .rxWord(rxWord), .txValid(txValid), .txWord(txWord),
    .rxSmpValid(rxSmpValid), .rxSample(rxSample)
  );
endmodule

// File: rtl/codec_seq_chk.sv
`timescale 1ns/1ps
module codec_seq_chk
  import codec_seq_pkg::*;
#(
  parameter int RX_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              txValid,
  input logic              txReady,
  input logic [WORD_W-1:0] txWord,
  input logic              smpValid,
  input logic              smpReady,
  input logic [SMP_W-1:0]  smpIn,
  input logic              swValid,
  input logic              swReady,
  input logic              rxValid,
  input logic [SMP_W-1:0]  rxWordHi,
  input logic              rxSmpValid,
  input logic [RX_W-1:0]   rxSample,
  input logic              codecRstN,
  input logic              cfgDone
);
  assert_hold_no_tx_R1: assert property (@(posedge clk) disable iff (!rstN)
    !codecRstN |-> !txValid);

  assert_busy_not_ready_R4: assert property (@(posedge clk) disable iff (!rstN)
    !cfgDone |-> (!smpReady && !swReady));

  assert_done_after_accept_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cfgDone) |-> $past(txValid && txReady));

  assert_stall_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txReady) |=> (txValid && $stable(txWord)));

  assert_primary_word_R6: assert property (@(posedge clk) disable iff (!rstN)
    (smpValid && smpReady) |=> (txValid && txWord == {$past(smpIn), TAG_PRI}));

  assert_switch_tag_R7: assert property (@(posedge clk) disable iff (!rstN)
    (swValid && swReady) |=> (txValid && txWord == {$past(smpIn), TAG_REQ}));

  assert_switch_first_R8: assert property (@(posedge clk) disable iff (!rstN)
    (swValid && smpValid) |-> !smpReady);

  assert_rx_extend_R9: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> (rxSmpValid &&
      rxSample == {{(RX_W-SMP_W){$past(rxWordHi[SMP_W-1])}}, $past(rxWordHi)}));
endmodule

bind codec_word_sequencer codec_seq_chk #(.RX_W(RX_W)) chk_i (
  .clk(clk), .rstN(rstN), .txValid(txValid), .txReady(txReady),
  .txWord(txWord), .smpValid(smpValid), .smpReady(smpReady), .smpIn(smpIn),
  .swValid(swValid), .swReady(swReady), .rxValid(rxValid),
  .rxWordHi(rxWord[15:2]), .rxSmpValid(rxSmpValid), .rxSample(rxSample),
  .codecRstN(codecRstN), .cfgDone(cfgDone)
);

// File: tb/codec_word_sequencer_tb.sv
`timescale 1ns/1ps
module codec_word_sequencer_tb_top;
  localparam int RST_CYC = 16;
  localparam int NVEC = 6;
  // {smpIn(14), rxWord(16), expected txWord(16), expected rxSample(32)}
  localparam logic [77:0] VEC [NVEC] = '{
    {14'h0000, 16'h0000, 16'h0000, 32'h0000_0000},
    {14'h1FFF, 16'h7FFC, 16'h7FFC, 32'h0000_1FFF},
    {14'h2000, 16'h8000, 16'h8000, 32'hFFFF_E000},
    {14'h3FFF, 16'hFFFF, 16'hFFFC, 32'hFFFF_FFFF},
    {14'h0123, 16'h0007, 16'h048C, 32'h0000_0001},
    {14'h2AAA, 16'hAAAA, 16'hAAA8, 32'hFFFF_EAAA}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [13:0] cfgA = 14'h058B, cfgB = 14'h1224, cfgCtl = 14'h0019;
  logic smpValid = 1'b0, swValid = 1'b0, swAux = 1'b0, txReady = 1'b0, rxValid = 1'b0;
  logic [13:0] smpIn = '0;
  logic [15:0] rxWord = '0;
  logic smpReady, swReady, txValid, rxSmpValid, codecRstN, cfgDone;
  logic [15:0] txWord;
  logic [31:0] rxSample;

  int total = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  codec_word_sequencer #(.RST_CYC(RST_CYC), .RX_W(32)) dut_i (
    .clk(clk), .rstN(rstN), .cfgA(cfgA), .cfgB(cfgB), .cfgCtl(cfgCtl),
    .smpValid(smpValid), .smpReady(smpReady), .smpIn(smpIn),
    .swValid(swValid), .swReady(swReady), .swAux(swAux),
    .txValid(txValid), .txReady(txReady), .txWord(txWord),
    .rxValid(rxValid), .rxWord(rxWord), .rxSmpValid(rxSmpValid),
    .rxSample(rxSample), .codecRstN(codecRstN), .cfgDone(cfgDone)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Starts and ends on a falling edge; holds the word for `stall` cycles first
  task automatic popWord(input int stall, output logic [15:0] w);
    int guard = 0;
    while (!txValid && guard < 200) begin
      @(negedge clk);
      guard++;
    end
    w = txWord;
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      chk(txValid && txWord == w, "R5 stall hold", {16'h0, txWord}, {16'h0, w});
    end
    txReady = 1'b1;
    @(posedge clk);
    #1 txReady = 1'b0;
    @(negedge clk);
  endtask

  task automatic sendSample(input logic [13:0] s, input logic [15:0] expTx, input string req);
    logic [15:0] w;
    chk(smpReady == 1'b1, "R11 ready when idle", {31'h0, smpReady}, 32'h1);
    smpValid = 1'b1;
    smpIn = s;
    @(posedge clk);
    #1 smpValid = 1'b0;
    @(negedge clk);
    chk(txValid && txWord == expTx, req, {16'h0, txWord}, {16'h0, expTx});
    popWord(0, w);
    chk(txValid == 1'b0, "R11 word not repeated", {31'h0, txValid}, 32'h0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [15:0] w;
    logic [15:0] cfgExp [6];
    int lowCnt;
    bit txDuringHold;
    cfgExp = '{16'h0003, 16'h162C, 16'h0003, 16'h4892, 16'h0003, 16'h0067};

    repeat (3) @(negedge clk);
    // R10 reset state
    chk(!txValid && !cfgDone && !rxSmpValid && !codecRstN, "R10 reset state",
        {28'h0, txValid, cfgDone, rxSmpValid, codecRstN}, 32'h0);

    rstN = 1'b1;
    lowCnt = 0;
    txDuringHold = 1'b0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (codecRstN) break;
      if (txValid) txDuringHold = 1'b1;
      lowCnt++;
    end
    // R1: rises on edge RST_CYC, so RST_CYC-1 falling-edge samples read low
    chk(lowCnt == RST_CYC - 1, "R1 reset hold length", lowCnt, RST_CYC - 1);
    chk(!txDuringHold, "R1 no word during hold", {31'h0, txDuringHold}, 32'h0);

    for (int i = 0; i < 6; i++) begin
      chk(smpReady == 1'b0 && swReady == 1'b0, "R4 not ready during setup",
          {30'h0, smpReady, swReady}, 32'h0);
      popWord(i % 3, w);
      chk(w == cfgExp[i], "R2 R3 setup word", {16'h0, w}, {16'h0, cfgExp[i]});
      if (i < 5) chk(cfgDone == 1'b0, "R4 done early", {31'h0, cfgDone}, 32'h0);
    end
    chk(cfgDone == 1'b1, "R4 done after sixth word", {31'h0, cfgDone}, 32'h1);

    for (int v = 0; v < NVEC; v++) begin
      smpIn = VEC[v][77:64];
      rxWord = VEC[v][63:48];
      chk(smpReady == 1'b1, "R11 ready when idle", {31'h0, smpReady}, 32'h1);
      smpValid = 1'b1;
      rxValid = 1'b1;
      @(posedge clk);
      #1;
      smpValid = 1'b0;
      rxValid = 1'b0;
      @(negedge clk);
      chk(txValid && txWord == VEC[v][47:32], "R6 primary word", {16'h0, txWord}, {16'h0, VEC[v][47:32]});
      chk(rxSmpValid && rxSample == VEC[v][31:0], "R9 sign extension", rxSample, VEC[v][31:0]);
      popWord(0, w);
      chk(!txValid && !rxSmpValid, "R11 R9 single word and pulse", {30'h0, txValid, rxSmpValid}, 32'h0);
    end

    // Switch to main input, with a sample offered at the same time
    swValid = 1'b1;
    swAux = 1'b0;
    smpValid = 1'b1;
    smpIn = 14'h1234;
    #0.5;
    chk(swReady && !smpReady, "R8 switch wins", {30'h0, swReady, smpReady}, 32'h2);
    @(posedge clk);
    #1;
    swValid = 1'b0;
    smpValid = 1'b0;
    @(negedge clk);
    chk(txValid && txWord == 16'h48D3, "R7 tagged switch word", {16'h0, txWord}, 32'h48D3);
    popWord(1, w);
    popWord(0, w);
    chk(w == 16'h0063, "R7 main-input control", {16'h0, w}, 32'h0063);
    sendSample(14'h0555, 16'h1554, "R7 back to primary");

    // Switch to auxiliary input
    swValid = 1'b1;
    swAux = 1'b1;
    smpIn = 14'h0F0F;
    @(posedge clk);
    #1 swValid = 1'b0;
    @(negedge clk);
    chk(txValid && txWord == 16'h3C3F, "R7 tagged switch word aux", {16'h0, txWord}, 32'h3C3F);
    popWord(0, w);
    popWord(2, w);
    chk(w == 16'h0073, "R7 aux-input control", {16'h0, w}, 32'h0073);
    sendSample(14'h3001, 16'hC004, "R7 back to primary after aux");

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule